// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block keeps a small ring of receive buffer descriptors in internal registers and moves through it as frames arrive. Each descriptor holds a 16-bit status word, a stored byte length and a buffer pointer. The receive side offers one finished frame at a time as a stored length, which includes the 4-byte frame check sequence, plus a last-fragment flag and an error flag. The block writes that frame into the descriptor at its fill index, but only when that descriptor is still marked empty. It then clears the empty flag and moves to the next slot. It returns to slot zero when the descriptor it just filled carries the wrap flag. If the slot at the fill index is not empty, the block stalls and accepts nothing until that slot is handed back.

The consumer side reads the descriptor at the drain index. It is told when that descriptor holds a deliverable frame: the last flag is set, the error flag is clear, and the payload (stored length minus 4) is more than 14 bytes. The consumer then releases the descriptor. Filled descriptors that fail this test are recycled by the block itself without being offered. Recycling rewrites a descriptor as empty with length zero, keeps the wrap flag on the final slot, and advances the drain index modulo the ring size.

Status bit positions are fixed: bit 15 empty, bit 13 wrap, bit 11 last, bit 0 error. All other bits read as zero.

Top module: `rx_ring_walker`

## Requirements
- R1: After reset every descriptor reads empty with stored length zero. Only the final slot also carries wrap, so slot 0 reads status 0x8000 and the final slot reads 0xA000. The fill and drain indices start at 0, rx_stall is 0, and cons_valid and fill_done are 0.
- R2: A frame is taken at a clock edge where frm_valid is 1 and the slot at the fill index has bit 15 (empty) set. The slot then holds length frm_len, bit 15 cleared, bit 11 equal to frm_last, bit 0 equal to frm_err, and bit 13 unchanged.
- R3: After taking a frame, the fill index moves to the next slot. If the filled slot had bit 13 (wrap) set, the fill index returns to slot 0.
- R4: While the slot at the fill index is not empty, rx_stall is 1 and frm_ready is 0. An offered frame then changes no descriptor and raises no fill_done.
- R5: fill_done is 1 for exactly the one cycle that follows each taken frame, and 0 otherwise.
- R6: cons_valid is 1 exactly when the slot at the drain index is filled, has bit 11 set and bit 0 clear, and has a stored length minus 4 greater than 14. cons_pay_len shows stored length minus 4, or 0 when the stored length is below 4.
- R7: A filled slot that does not meet the R6 test is recycled one cycle after it appears at the drain index, with cons_valid staying 0.
- R8: A release (cons_release while cons_valid is 1) rewrites the slot as empty with length zero, as 0xA000 for the final slot and 0x8000 otherwise. It also advances the drain index modulo the ring size. cons_release while cons_valid is 0 has no effect.
- R9: A frame held on frm_valid during a stall is taken on the edge after the stalling slot is released, with fill_done following one cycle later.
- R10: cons_ptr shows the buffer pointer of the slot at the drain index, equal to BUF_BASE plus the slot index times BUF_SPAN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, initialises the ring |
| frm_valid | input | 1 | A completed frame is offered |
| frm_len | input | LEN_W | Stored frame length including the 4-byte check sequence |
| frm_last | input | 1 | Frame ends in this descriptor |
| frm_err | input | 1 | Frame was received with an error |
| frm_ready | output | 1 | The slot at the fill index can take a frame |
| rx_stall | output | 1 | The slot at the fill index is not empty |
| fill_done | output | 1 | One-cycle pulse after a descriptor is filled |
| cons_valid | output | 1 | The slot at the drain index holds a deliverable frame |
| cons_release | input | 1 | Hand the deliverable descriptor back as empty |
| cons_idx | output | IDX_W | Drain index |
| cons_stat | output | 16 | Status word of the slot at the drain index |
| cons_len | output | LEN_W | Stored length of the slot at the drain index |
| cons_pay_len | output | LEN_W | Payload length (stored length minus 4, floored at 0) |
| cons_ptr | output | PTR_W | Buffer pointer of the slot at the drain index |

## Verification
The bench builds the block with a ring of four slots, 12-bit lengths and a buffer span of 0x800. With four slots, the wrap return from the final descriptor is reached twice within eight frames. This lets slots that were already recycled be seen again, including the wrap flag kept on the final slot. Four deliverable frames with no release fill the ring and bring the stall within reach, and releasing slot 0 with a frame still offered then shows the resume. The 12-bit length reaches the payload boundary at stored lengths 18 and 19, a stored length below the check sequence, and a full 1518-byte frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int unsigned ST_W        = 16;
  localparam int unsigned ST_EMPTY    = 15;
  localparam int unsigned ST_WRAP     = 13;
  localparam int unsigned ST_LAST     = 11;
  localparam int unsigned ST_ERR      = 0;
  localparam int unsigned FCS_BYTES   = 4;
  localparam int unsigned MIN_PAYLOAD = 14;

  typedef logic [ST_W-1:0] rxr_stat_t;

  // Status of a recycled or freshly initialised descriptor.
  function automatic rxr_stat_t stat_blank(input logic wrap_f);
    rxr_stat_t s;
    s           = '0;
    s[ST_EMPTY] = 1'b1;
    s[ST_WRAP]  = wrap_f;
    return s;
  endfunction

  // Status of a descriptor just written with a frame.
  function automatic rxr_stat_t stat_filled(input logic wrap_f, input logic last_f,
                                            input logic err_f);
    rxr_stat_t s;
    s          = '0;
    s[ST_WRAP] = wrap_f;
    s[ST_LAST] = last_f;
    s[ST_ERR]  = err_f;
    return s;
  endfunction

  // Payload bytes: stored length minus the check sequence, floored at zero.
  function automatic int unsigned payload_bytes(input int unsigned stored);
    return (stored > FCS_BYTES) ? stored - FCS_BYTES : 0;
  endfunction

  // A filled descriptor is handed to the consumer only when this is true.
  function automatic logic deliverable(input rxr_stat_t s, input int unsigned stored);
    return s[ST_LAST] && !s[ST_ERR] && (stored > FCS_BYTES + MIN_PAYLOAD);
  endfunction

endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned PTR_W     = 32,
  parameter logic [31:0] BUF_BASE  = 32'h1000_0000,
  parameter logic [31:0] BUF_SPAN  = 32'h0000_0800,
  localparam int unsigned IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [LEN_W-1:0] fill_len,
  input  logic             fill_last,
  input  logic             fill_err,
  input  logic             free_en,
  input  logic [IDX_W-1:0] free_idx,
  output logic             prod_empty,
  output logic             prod_wrap,
  input  logic [IDX_W-1:0] rd_idx,
  output rxr_stat_t        rd_stat,
  output logic [LEN_W-1:0] rd_len,
  output logic [PTR_W-1:0] rd_ptr
);

  rxr_stat_t [DEPTH-1:0]        stat_w;
  logic [DEPTH-1:0][LEN_W-1:0]  len_w;
  logic [DEPTH-1:0][PTR_W-1:0]  ptr_w;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    localparam logic IS_END = (gi == DEPTH - 1);
    rxr_stat_t        st_q;
    logic [LEN_W-1:0] ln_q;
    logic [PTR_W-1:0] pt_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= stat_blank(IS_END);
        ln_q <= '0;
        pt_q <= PTR_W'(BUF_BASE + BUF_SPAN * gi);
      end else if (fill_en && (fill_idx == IDX_W'(gi))) begin
        st_q <= stat_filled(st_q[ST_WRAP], fill_last, fill_err);
        ln_q <= fill_len;
      end else if (free_en && (free_idx == IDX_W'(gi))) begin
        st_q <= stat_blank(IS_END);
        ln_q <= '0;
      end
    end

    assign stat_w[gi] = st_q;
    assign len_w[gi]  = ln_q;
    assign ptr_w[gi]  = pt_q;
  end

  assign prod_empty = stat_w[fill_idx][ST_EMPTY];
  assign prod_wrap  = stat_w[fill_idx][ST_WRAP];
  assign rd_stat    = stat_w[rd_idx];
  assign rd_len     = len_w[rd_idx];
  assign rd_ptr     = ptr_w[rd_idx];

  // R2
  fill_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> stat_w[fill_idx][ST_EMPTY]);

  // R8
  free_only_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> !stat_w[free_idx][ST_EMPTY]);

  // R2
  no_port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && free_en) |-> (fill_idx != free_idx));

endmodule

// File: rtl/rxr_fill_ctl.sv
module rxr_fill_ctl #(
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic             slot_empty,
  input  logic             slot_wrap,
  output logic             take,
  output logic [IDX_W-1:0] prod_idx,
  output logic             frm_ready,
  output logic             rx_stall,
  output logic             fill_done
);

  logic [IDX_W-1:0] idx_next;

  assign frm_ready = slot_empty;
  assign rx_stall  = !slot_empty;
  assign take      = frm_valid && slot_empty;
  assign idx_next  = slot_wrap ? '0 : prod_idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_idx  <= '0;
      fill_done <= 1'b0;
    end else begin
      fill_done <= take;
      if (take) prod_idx <= idx_next;
    end
  end

  if (DEPTH > 1) begin : g_adv_chk
    // R3
    fill_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (prod_idx != $past(prod_idx)));
  end

  // R4
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stall && frm_valid) |=> $stable(prod_idx));

endmodule

// File: rtl/rxr_drain_ctl.sv
module rxr_drain_ctl
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LEN_W  = 12,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rxr_stat_t        slot_stat,
  input  logic [LEN_W-1:0] slot_len,
  input  logic             cons_release,
  output logic [IDX_W-1:0] cons_idx,
  output logic             cons_valid,
  output logic [LEN_W-1:0] pay_len,
  output logic             free_en
);

  logic avail;
  logic pass;
  logic drop;

  assign avail      = !slot_stat[ST_EMPTY];
  assign pass       = deliverable(slot_stat, 32'(slot_len));
  assign cons_valid = avail && pass;
  assign drop       = avail && !pass;
  assign free_en    = drop || (cons_release && cons_valid);
  assign pay_len    = LEN_W'(payload_bytes(32'(slot_len)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cons_idx <= '0;
    end else if (free_en) begin
      cons_idx <= (cons_idx == IDX_W'(DEPTH - 1)) ? '0 : cons_idx + IDX_W'(1);
    end
  end

  // R6
  payload_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_valid |-> (pay_len > LEN_W'(MIN_PAYLOAD)));

  if (DEPTH > 1) begin : g_adv_chk
    // R8
    drain_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_en |=> (cons_idx != $past(cons_idx)));
  end

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail) |=> $stable(cons_idx));

endmodule

// File: rtl/rx_ring_walker.sv
module rx_ring_walker
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned PTR_W     = 32,
  parameter logic [31:0] BUF_BASE  = 32'h1000_0000,
  parameter logic [31:0] BUF_SPAN  = 32'h0000_0800,
  localparam int unsigned IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_last,
  input  logic             frm_err,
  output logic             frm_ready,
  output logic             rx_stall,
  output logic             fill_done,
  output logic             cons_valid,
  input  logic             cons_release,
  output logic [IDX_W-1:0] cons_idx,
  output logic [15:0]      cons_stat,
  output logic [LEN_W-1:0] cons_len,
  output logic [LEN_W-1:0] cons_pay_len,
  output logic [PTR_W-1:0] cons_ptr
);

  logic             take;
  logic [IDX_W-1:0] prod_idx;
  logic             prod_empty;
  logic             prod_wrap;
  logic             free_en;
  rxr_stat_t        rd_stat;

  rxr_desc_store #(
    .DEPTH(DEPTH), .LEN_W(LEN_W), .PTR_W(PTR_W),
    .BUF_BASE(BUF_BASE), .BUF_SPAN(BUF_SPAN)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .fill_en(take), .fill_idx(prod_idx), .fill_len(frm_len),
    .fill_last(frm_last), .fill_err(frm_err),
    .free_en(free_en), .free_idx(cons_idx),
    .prod_empty(prod_empty), .prod_wrap(prod_wrap),
    .rd_idx(cons_idx), .rd_stat(rd_stat), .rd_len(cons_len), .rd_ptr(cons_ptr)
  );

  rxr_fill_ctl #(.DEPTH(DEPTH)) fill_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
    .slot_empty(prod_empty), .slot_wrap(prod_wrap),
    .take(take), .prod_idx(prod_idx), .frm_ready(frm_ready),
    .rx_stall(rx_stall), .fill_done(fill_done)
  );

  rxr_drain_ctl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) drain_i (
    .clk(clk), .rst_n(rst_n), .slot_stat(rd_stat), .slot_len(cons_len),
    .cons_release(cons_release), .cons_idx(cons_idx), .cons_valid(cons_valid),
    .pay_len(cons_pay_len), .free_en(free_en)
  );

  assign cons_stat = rd_stat;

  // R4
  stall_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stall |=> !fill_done);

  // R7
  reject_not_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cons_stat[ST_EMPTY] && cons_stat[ST_ERR]) |-> !cons_valid);

endmodule

// File: tb/rx_ring_walker_tb.sv
module rx_ring_walker_tb_top;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned LEN_W = 12;
  localparam int unsigned PTR_W = 32;
  localparam logic [31:0] BASE  = 32'h1000_0000;
  localparam logic [31:0] SPAN  = 32'h0000_0800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic frm_last = 1'b0;
  logic frm_err = 1'b0;
  logic cons_release = 1'b0;
  logic frm_ready, rx_stall, fill_done, cons_valid;
  logic [1:0] cons_idx;
  logic [15:0] cons_stat;
  logic [LEN_W-1:0] cons_len, cons_pay_len;
  logic [PTR_W-1:0] cons_ptr;

  int checks = 0;
  int errs = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_ring_walker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .PTR_W(PTR_W),
                   .BUF_BASE(BASE), .BUF_SPAN(SPAN)) dut_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_last(frm_last), .frm_err(frm_err), .frm_ready(frm_ready),
    .rx_stall(rx_stall), .fill_done(fill_done), .cons_valid(cons_valid),
    .cons_release(cons_release), .cons_idx(cons_idx), .cons_stat(cons_stat),
    .cons_len(cons_len), .cons_pay_len(cons_pay_len), .cons_ptr(cons_ptr)
  );

  // {stored length, last, err, deliverable}
  localparam logic [14:0] VEC [8] = '{
    {12'd64,   1'b1, 1'b0, 1'b1},
    {12'd18,   1'b1, 1'b0, 1'b0},
    {12'd19,   1'b1, 1'b0, 1'b1},
    {12'd100,  1'b1, 1'b1, 1'b0},
    {12'd200,  1'b0, 1'b0, 1'b0},
    {12'd3,    1'b1, 1'b0, 1'b0},
    {12'd1518, 1'b1, 1'b0, 1'b1},
    {12'd4,    1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] blank_of(input int i);
    return (i == DEPTH - 1) ? 16'hA000 : 16'h8000;
  endfunction

  task automatic offer(input int len, input logic l, input logic e);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = LEN_W'(len); frm_last = l; frm_err = e;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic release_one();
    cons_release = 1'b1;
    @(negedge clk);
    cons_release = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_stall", 32'(rx_stall), 0);
    chk("R1 frm_ready", 32'(frm_ready), 1);
    chk("R1 cons_valid", 32'(cons_valid), 0);
    chk("R1 fill_done", 32'(fill_done), 0);
    chk("R1 cons_idx", 32'(cons_idx), 0);
    chk("R1 cons_stat", 32'(cons_stat), 32'h8000);
    chk("R1 cons_len", 32'(cons_len), 0);
    // R8 release with nothing deliverable is ignored
    release_one();
    chk("R8 idle release idx", 32'(cons_idx), 0);
    chk("R8 idle release stat", 32'(cons_stat), 32'h8000);

    // Vector walk: two laps of the ring
    for (int v = 0; v < 8; v++) begin
      int len; logic l, e, d; int nb; logic [15:0] st;
      len = int'(VEC[v][14:3]); l = VEC[v][2]; e = VEC[v][1]; d = VEC[v][0];
      offer(len, l, e);
      st = ((b == DEPTH - 1) ? 16'h2000 : 16'h0) | (l ? 16'h0800 : 16'h0) | (e ? 16'h0001 : 16'h0);
      chk("R5 fill_done pulse", 32'(fill_done), 1);
      chk("R2 cons_idx", 32'(cons_idx), 32'(b));
      chk("R2 status", 32'(cons_stat), 32'(st));
      chk("R2 length", 32'(cons_len), 32'(len));
      chk("R6 cons_valid", 32'(cons_valid), 32'(d));
      chk("R6 payload", 32'(cons_pay_len), (len > 4) ? 32'(len - 4) : 0);
      chk("R10 pointer", cons_ptr, BASE + SPAN * b);
      chk("R3 no stall", 32'(rx_stall), 0);
      if (d) release_one();
      else @(negedge clk);
      nb = (b + 1) % DEPTH;
      chk(d ? "R8 drain advance" : "R7 auto recycle", 32'(cons_idx), 32'(nb));
      chk("R5 pulse ends", 32'(fill_done), 0);
      chk("R8 slot empty", 32'(cons_stat), 32'(blank_of(nb)));
      chk("R8 slot len zero", 32'(cons_len), 0);
      b = nb;
    end

    // R3/R4 fill the ring without releasing
    for (int j = 0; j < DEPTH; j++) begin
      offer(50 + j, 1'b1, 1'b0);
      chk("R5 fill pulse", 32'(fill_done), 1);
    end
    chk("R4 stall", 32'(rx_stall), 1);
    chk("R4 ready low", 32'(frm_ready), 0);
    chk("R3 wrap back", 32'(cons_stat), 32'h0800);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 12'd77; frm_last = 1'b1; frm_err = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4 no fill_done", 32'(fill_done), 0);
      chk("R4 slot untouched", 32'(cons_len), 50);
    end
    // R9 release slot 0 while frame stays offered
    cons_release = 1'b1;
    @(negedge clk);
    cons_release = 1'b0;
    chk("R9 stall clears", 32'(rx_stall), 0);
    chk("R9 cons_idx", 32'(cons_idx), 1);
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R9 taken", 32'(fill_done), 1);
    chk("R9 stall again", 32'(rx_stall), 1);
    for (int j = 1; j < DEPTH; j++) begin
      chk("R6 in order", 32'(cons_len), 32'(50 + j));
      release_one();
    end
    chk("R9 resumed frame len", 32'(cons_len), 77);
    chk("R9 resumed frame stat", 32'(cons_stat), 32'h0800);
    chk("R6 resumed valid", 32'(cons_valid), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule